// File: doc/BRIEF.md
# Carrier-Based PWM Channel with Shadowed Duty and Phase

This block turns a duty value into a complementary pair of gate signals. It builds a carrier from a shared, free-running time-base count, either as a sawtooth or as a triangle. It can shift that carrier by a phase offset. The high-side gate is on while the active duty is greater than the carrier. The low-side gate is the complement, with optional dead time between the two.

Software writes duty and phase into shadow registers at any time. The comparator uses only the active copies. These are loaded from the shadow registers at carrier events: at the carrier zero only, or at both the zero and the triangle peak when double-rate updating is chosen. This keeps every switching period internally consistent. An enable input forces both gates low without blocking shadow writes.

Top module: `carrier_pwm`

## Requirements
- R1: During reset, and after reset until `enable` is raised, both `gate_hi` and `gate_lo` are 0.
- R2: With dead time off, the outputs at a clock edge reflect the `tb_count` sampled two edges earlier. `gate_hi` = (active duty > carrier) and `gate_lo` = !`gate_hi`. In sawtooth mode (`tri_shape`=0) the carrier equals the phase-shifted count, 0 to `period`-1.
- R3: In triangle mode (`tri_shape`=1, `period` even, half = `period`/2) the carrier is 2·p for a shifted count p < half, and 2·(`period`-1-p)+1 otherwise. Any duty d below `period` therefore gives d high cycles per period.
- R4: The shifted count is (`tb_count` + active phase) modulo `period`, for a phase below `period`.
- R5: A write pulse on `wr_stb` loads the shadow duty and phase. The active copies take the shadow values only at the sample whose shifted count is 0, and that sample already uses the new duty.
- R6: With `dbl_rate`=1 in triangle mode, the active copies also load at the sample whose shifted count equals half (the carrier peak).
- R7: In sawtooth mode, `dbl_rate`=1 behaves exactly like `dbl_rate`=0. Updates happen only at shifted count 0.
- R8: A duty of 0 keeps `gate_hi` low for the whole period. A duty equal to or above `period` keeps it high for the whole period.
- R9: With `dt_on`=1 and `dt_len`=N>0, both gates are low for N cycles after every comparator edge before the new side turns on. With `dt_len`=0 the outputs behave as with dead time off.
- R10: A comparator pulse shorter than the dead time produces no output pulse. `gate_hi` and `gate_lo` are never 1 together.
- R11: While `enable`=0, both gates are 0 from the next edge on. Shadow writes and event-timed loads of the active copies continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output enable; 0 forces both gates low |
| tb_count | input | CW | Shared time-base count, 0 to period-1 |
| period | input | CW | Length of the time-base cycle in clocks (even for triangle) |
| wr_stb | input | 1 | Loads duty_wr and phase_wr into the shadow registers |
| duty_wr | input | CW | Duty value to shadow, in carrier units |
| phase_wr | input | CW | Phase offset to shadow, below period |
| tri_shape | input | 1 | 0 sawtooth carrier, 1 triangle carrier |
| dbl_rate | input | 1 | 1 adds the triangle peak as an update event |
| dt_on | input | 1 | Enables dead-time insertion |
| dt_len | input | DTW | Dead-time length in clocks |
| gate_hi | output | 1 | High-side gate |
| gate_lo | output | 1 | Low-side gate |

## Verification
Several properties are checked on every clock: the gates never overlap, disabling forces both gates low at the next edge, a rising gate under dead time is preceded by a cycle with the opposite gate off, and the active duty changes only on an update event. Single-rate and sawtooth loads are also checked to fall only on a zero carrier. The actual carrier shapes, the phase rotation, and the exact sample at which a shadow write takes effect under each update rate can only be shown by the bench. The bench compares each output sample against a model of the carrier. The same holds for the dead-time cycle counts and the suppression of short pulses, which the bench measures per period.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  typedef enum logic {
    CAR_SAW = 1'b0,
    CAR_TRI = 1'b1
  } car_shape_e;
endpackage

// File: rtl/pwm_carrier_gen.sv
`timescale 1ns/1ps
// Phase rotation of the time-base count and carrier shaping (combinational).
module pwm_carrier_gen
  import pwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [CW-1:0] tb_count,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] phase_act,
  input  car_shape_e    shape,
  output logic [CW-1:0] carrier,
  output logic          at_zero,
  output logic          at_peak
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum_w;
  logic [SW-1:0] wrap_w;
  logic [CW-1:0] shifted;
  logic [CW-1:0] half;
  logic [CW-1:0] mirror;

  always_comb begin
    sum_w  = {1'b0, tb_count} + {1'b0, phase_act};
    wrap_w = sum_w - {1'b0, period};
    if (sum_w >= {1'b0, period}) shifted = wrap_w[CW-1:0];
    else                         shifted = sum_w[CW-1:0];
    half   = period >> 1;
    mirror = period - shifted - CW'(1);
  end

  always_comb begin
    if (shape == CAR_SAW)   carrier = shifted;
    else if (shifted < half) carrier = {shifted[CW-2:0], 1'b0};
    else                    carrier = {mirror[CW-2:0], 1'b1};
  end

  assign at_zero = (shifted == '0);
  assign at_peak = (shape == CAR_TRI) && (shifted == half);
endmodule

// File: rtl/pwm_shadow_cmp.sv
`timescale 1ns/1ps
// Shadow and active duty/phase registers plus the registered comparator.
module pwm_shadow_cmp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          wr_stb,
  input  logic [CW-1:0] duty_wr,
  input  logic [CW-1:0] phase_wr,
  input  logic          at_zero,
  input  logic          at_peak,
  input  logic          dbl_rate,
  input  logic          saw_mode,
  input  logic [CW-1:0] carrier,
  output logic [CW-1:0] phase_act,
  output logic          cmp_out
);
  logic [CW-1:0] duty_sh;
  logic [CW-1:0] phase_sh;
  logic [CW-1:0] duty_act;
  logic [CW-1:0] duty_eff;
  logic          upd;

  assign upd      = at_zero || (dbl_rate && at_peak);
  assign duty_eff = upd ? duty_sh : duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh   <= '0;
      phase_sh  <= '0;
      duty_act  <= '0;
      phase_act <= '0;
      cmp_out   <= 1'b0;
    end else begin
      if (wr_stb) begin
        duty_sh  <= duty_wr;
        phase_sh <= phase_wr;
      end
      if (upd) begin
        duty_act  <= duty_sh;
        phase_act <= phase_sh;
      end
      cmp_out <= enable && (duty_eff > carrier);
    end
  end

  // R5: the active duty moves only on an update event
  assert_active_on_event_R5: assert property (@(posedge clk) disable iff (rst)
    (duty_act != $past(duty_act)) |-> $past(upd));

  // R5: at single rate, a load falls on a zero carrier
  assert_single_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ((duty_act != $past(duty_act)) && !$past(dbl_rate)) |-> ($past(carrier) == '0));

  // R7: in sawtooth mode, a load falls on a zero carrier whatever the rate
  assert_saw_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ((duty_act != $past(duty_act)) && $past(saw_mode)) |-> ($past(carrier) == '0));
endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
// Complementary output stage with dead-time insertion after each comparator edge.
module pwm_deadband #(
  parameter int DTW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           dt_on,
  input  logic [DTW-1:0] dt_len,
  input  logic           cmp_in,
  output logic           gate_hi,
  output logic           gate_lo
);
  logic           cmp_d;
  logic [DTW-1:0] hold;
  logic           use_dt;
  logic           cmp_edge;

  assign use_dt   = dt_on && (dt_len != '0);
  assign cmp_edge = cmp_in ^ cmp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_d   <= 1'b0;
      hold    <= '0;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      cmp_d <= cmp_in;
      if (!enable) begin
        hold    <= '0;
        gate_hi <= 1'b0;
        gate_lo <= 1'b0;
      end else if (use_dt && cmp_edge) begin
        hold    <= dt_len - DTW'(1);
        gate_hi <= 1'b0;
        gate_lo <= 1'b0;
      end else if (hold != '0) begin
        hold    <= hold - DTW'(1);
        gate_hi <= 1'b0;
        gate_lo <= 1'b0;
      end else begin
        gate_hi <= cmp_in;
        gate_lo <= !cmp_in;
      end
    end
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  assert_disable_low_R11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!gate_hi && !gate_lo));

  assert_gap_before_hi_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_hi) && $past(use_dt)) |-> !$past(gate_lo));

  assert_gap_before_lo_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_lo) && $past(use_dt)) |-> !$past(gate_hi));
endmodule

// File: rtl/carrier_pwm.sv
`timescale 1ns/1ps
module carrier_pwm
  import pwm_pkg::*;
#(
  parameter int CW  = 8,
  parameter int DTW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic [CW-1:0]  tb_count,
  input  logic [CW-1:0]  period,
  input  logic           wr_stb,
  input  logic [CW-1:0]  duty_wr,
  input  logic [CW-1:0]  phase_wr,
  input  logic           tri_shape,
  input  logic           dbl_rate,
  input  logic           dt_on,
  input  logic [DTW-1:0] dt_len,
  output logic           gate_hi,
  output logic           gate_lo
);
  car_shape_e    shape;
  logic [CW-1:0] carrier;
  logic [CW-1:0] phase_act;
  logic          at_zero;
  logic          at_peak;
  logic          cmp_q;

  assign shape = tri_shape ? CAR_TRI : CAR_SAW;

  pwm_carrier_gen #(.CW(CW)) u_carrier (
    .tb_count (tb_count),
    .period   (period),
    .phase_act(phase_act),
    .shape    (shape),
    .carrier  (carrier),
    .at_zero  (at_zero),
    .at_peak  (at_peak)
  );

  pwm_shadow_cmp #(.CW(CW)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .wr_stb   (wr_stb),
    .duty_wr  (duty_wr),
    .phase_wr (phase_wr),
    .at_zero  (at_zero),
    .at_peak  (at_peak),
    .dbl_rate (dbl_rate),
    .saw_mode (shape == CAR_SAW),
    .carrier  (carrier),
    .phase_act(phase_act),
    .cmp_out  (cmp_q)
  );

  pwm_deadband #(.DTW(DTW)) u_deadband (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .dt_on  (dt_on),
    .dt_len (dt_len),
    .cmp_in (cmp_q),
    .gate_hi(gate_hi),
    .gate_lo(gate_lo)
  );
endmodule

// File: tb/carrier_pwm_test.sv
`timescale 1ns/1ps
module carrier_pwm_test;
  localparam int CW  = 8;
  localparam int DTW = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           enable = 1'b0;
  logic [CW-1:0]  cnt = '0;
  logic [CW-1:0]  prd = 8'd16;
  logic           wr_stb = 1'b0;
  logic [CW-1:0]  duty_w = '0;
  logic [CW-1:0]  phase_w = '0;
  logic           tri_shape = 1'b0;
  logic           dbl_rate = 1'b0;
  logic           dt_on = 1'b0;
  logic [DTW-1:0] dt_len = '0;
  logic           gate_hi;
  logic           gate_lo;

  int n_chk = 0;
  int n_bad = 0;
  int m_phase = 0;
  logic [CW-1:0] tag = '0;
  logic [CW-1:0] held = '0;
  bit done = 0;

  carrier_pwm #(.CW(CW), .DTW(DTW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .tb_count(cnt), .period(prd),
    .wr_stb(wr_stb), .duty_wr(duty_w), .phase_wr(phase_w), .tri_shape(tri_shape),
    .dbl_rate(dbl_rate), .dt_on(dt_on), .dt_len(dt_len),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #4 clk = ~clk;

  // time base; tag is the count whose result is visible at this negedge
  initial forever begin
    @(negedge clk);
    tag  = held;
    held = cnt;
    cnt  = (cnt == prd - 1) ? '0 : cnt + 1'b1;
  end

  function automatic logic model_hi(int t, int d, int p, logic tri_m, int pr);
    int pc;
    int car;
    pc = (t + p) % pr;
    if (!tri_m)          car = pc;
    else if (pc < pr/2)  car = 2 * pc;
    else                 car = 2 * (pr - 1 - pc) + 1;
    return d > car;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_cycles(int n, int d, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      @(negedge clk); #1;
      e = model_hi(int'(tag), d, m_phase, tri_shape, int'(prd));
      if (gate_hi !== e || gate_lo !== !e) begin
        if (bad == 0) $display("  first mismatch at carrier index %0d", tag);
        bad++;
      end
    end
    check_eq(req, "mismatching samples", bad, 0);
  endtask

  task automatic count_period(output int hi_n, output int lo_n, output int none_n,
                              output int both_n);
    hi_n = 0; lo_n = 0; none_n = 0; both_n = 0;
    for (int i = 0; i < int'(prd); i++) begin
      @(negedge clk); #1;
      if (gate_hi && gate_lo) both_n++;
      else if (gate_hi) hi_n++;
      else if (gate_lo) lo_n++;
      else none_n++;
    end
  endtask

  task automatic write_sh(int d, int p);
    duty_w = CW'(d);
    phase_w = CW'(p);
    wr_stb = 1'b1;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * int'(prd) + 4) @(negedge clk);
  endtask

  task automatic wait_cnt(int v);
    do begin
      @(negedge clk); #1;
    end while (int'(cnt) != v);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check_eq("R1", "gate_hi in reset", gate_hi, 0);
    check_eq("R1", "gate_lo in reset", gate_lo, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check_eq("R1", "gates low before enable", gate_hi | gate_lo, 0);
  endtask

  task automatic t_sawtooth();
    enable = 1'b1; tri_shape = 1'b0; dbl_rate = 1'b0;
    write_sh(6, 0); m_phase = 0; settle();
    check_cycles(32, 6, "R2");
  endtask

  task automatic t_bounds();
    int h, l, z, b;
    write_sh(0, 0); settle(); count_period(h, l, z, b);
    check_eq("R8", "high cycles at duty 0", h, 0);
    write_sh(16, 0); settle(); count_period(h, l, z, b);
    check_eq("R8", "high cycles at duty=period", h, 16);
    write_sh(200, 0); settle(); count_period(h, l, z, b);
    check_eq("R8", "high cycles at duty 200", h, 16);
  endtask

  task automatic t_phase_saw();
    write_sh(6, 5); m_phase = 5; settle();
    check_cycles(32, 6, "R4");
  endtask

  task automatic t_triangle();
    tri_shape = 1'b1;
    write_sh(6, 0); m_phase = 0; settle();
    check_cycles(32, 6, "R3");
    write_sh(9, 3); m_phase = 3; settle();
    check_cycles(32, 9, "R4");
    write_sh(4, 0); m_phase = 0; settle();
  endtask

  task automatic t_single_saw();
    tri_shape = 1'b0; dbl_rate = 1'b0;
    write_sh(4, 0); m_phase = 0; settle();
    wait_cnt(6); write_sh(12, 0);
    check_cycles(11, 4, "R5");
    check_cycles(16, 12, "R5");
  endtask

  task automatic t_double_tri();
    tri_shape = 1'b1; dbl_rate = 1'b1;
    write_sh(4, 0); settle();
    wait_cnt(2); write_sh(12, 0);
    check_cycles(7, 4, "R6");
    check_cycles(24, 12, "R6");
    dbl_rate = 1'b0;
    write_sh(4, 0); settle();
    wait_cnt(2); write_sh(12, 0);
    check_cycles(15, 4, "R5");
    check_cycles(16, 12, "R5");
  endtask

  task automatic t_double_saw();
    tri_shape = 1'b0; dbl_rate = 1'b1;
    write_sh(4, 0); settle();
    wait_cnt(6); write_sh(12, 0);
    check_cycles(11, 4, "R7");
    check_cycles(16, 12, "R7");
    dbl_rate = 1'b0;
  endtask

  task automatic t_deadtime();
    int h, l, z, b;
    dt_on = 1'b1; dt_len = 6'd2;
    write_sh(6, 0); settle(); count_period(h, l, z, b);
    check_eq("R9", "high cycles, dead time 2", h, 4);
    check_eq("R9", "low cycles, dead time 2", l, 8);
    check_eq("R9", "both-off cycles, dead time 2", z, 4);
    dt_len = 6'd0; settle(); count_period(h, l, z, b);
    check_eq("R9", "high cycles, dead time 0", h, 6);
    check_eq("R9", "low cycles, dead time 0", l, 10);
  endtask

  task automatic t_short_pulse();
    int h, l, z, b;
    dt_len = 6'd3;
    write_sh(1, 0); settle(); count_period(h, l, z, b);
    check_eq("R10", "high cycles of short pulse", h, 0);
    check_eq("R10", "low cycles with short pulse", l, 12);
    check_eq("R10", "overlapping cycles", b, 0);
    dt_on = 1'b0; dt_len = '0;
  endtask

  task automatic t_enable();
    int h, l, z, b;
    write_sh(6, 0); settle();
    enable = 1'b0;
    repeat (2) @(negedge clk);
    count_period(h, l, z, b);
    check_eq("R11", "active gate cycles while disabled", h + l + b, 0);
    write_sh(10, 0);
    repeat (2 * int'(prd)) @(negedge clk);
    enable = 1'b1;
    settle();
    check_cycles(32, 10, "R11");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sawtooth();
    t_bounds();
    t_phase_saw();
    t_triangle();
    t_single_saw();
    t_double_tri();
    t_double_saw();
    t_deadtime();
    t_short_pulse();
    t_enable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule